// File: doc/BRIEF.md
# Banked Memory Translator with Switchable Lookup Tables

This block sits between an 8-bit CPU with a 16-bit address bus and a larger physical memory. The CPU space is cut into eight 8 KB windows. Each window is redirected to any 8 KB block of a 10-bit block space. Four separate lookup tables of eight entries are held. One of them translates at any time. Software can rewrite another table in the background and then switch to it with a single register write.

Every CPU cycle is treated as an access, and every access produces four results. The first is a physical block number plus the untouched 13-bit offset. The second is a device class, which is decoded from the block number or forced to IO when the IO window covers slot 6. The third is the current IO page. The last is a flag that marks accesses claimed by the translator's own registers; it tells the memory side to stay off the bus. Two control registers are always present at addresses 0 and 1. The table-editing registers at 2, 3 and 8 to 15 appear only while the edit gate is open. Some control bits are only stored and driven out: the move bits, the sprite bank bit and the extended-SRAM enable.

Top module: `mmu_bank_xlat`

## Requirements
- R1: CPU address bits [15:13] pick the slot, and `phys_offset` always equals CPU address bits [12:0] in the same cycle.
- R2: After reset, every table maps slot n to block n. Both control registers read 0, the IO window is on with IO page 0, and editing is off.
- R3: Bits [1:0] of address 0 choose which table drives `phys_block`. A write takes effect on the cycle after the write cycle.
- R4: Address 0 reads back its edit gate at bit 7, its edit-table field at [5:4], its extended-SRAM enable at bit 3 and its active-table field at [1:0]. Bits 6 and 2 always read 0. Bit 3 is driven on `xsram_en`.
- R5: Address 1 holds several fields and reads them back, with bit 7 reading 0:
  - sprite bank select at bit 6, on `sprite_sel`;
  - flash/cartridge move at bit 5, on `move_flash`;
  - IO move at bit 4, on `move_io`;
  - IO page high bit at bit 3;
  - IO window disable at bit 2;
  - IO page low bits at [1:0].
- R6: With the gate open, addresses 8 to 15 read and write bits [7:0] of the block number of slots 0 to 7 in the table chosen for editing.
- R7: With the gate open, address 2 holds bits [9:8] of slots 0 to 3 and address 3 those of slots 4 to 7. Each slot takes two bits, and the lowest slot of each group sits in bits [1:0].
- R8: Editing a table other than the active one leaves the current translation unchanged.
- R9: With the gate closed, addresses 2, 3 and 8 to 15 are plain memory. `reg_hit` is 0, `cpu_rdata` is 0 and a write changes no table.
- R10: When the IO-disable bit is 0, slot 6 reports device IO whatever the active table holds. When it is 1, slot 6 is decoded like any other slot. `io_page` is always {bit 3, bits [1:0]} of address 1.
- R11: The device class comes from block bits [7:0]; bits [9:8] are ignored, so upper block pages mirror the layout. The classes are:
  - $00 to $3F: SRAM, code 0;
  - $40 to $7F: flash, code 1;
  - $80 to $9F: cartridge, code 2;
  - $A0 to $FF: reserved, code 3;
  - IO: code 4.
- R12: `reg_hit` is 1 for addresses 0 and 1 at all times. On any access that is not a register hit, `cpu_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address of the current access |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | Write strobe for the current access |
| cpu_rdata | output | 8 | Register read data, 0 when no register is hit |
| reg_hit | output | 1 | Access claimed by a translator register |
| phys_block | output | 10 | Block number from the active table for the slot |
| phys_offset | output | 13 | Byte offset inside the block |
| dev_class | output | 3 | Device class code (see R11) |
| io_page | output | 3 | Selected IO page |
| xsram_en | output | 1 | Stored extended-SRAM enable |
| move_io | output | 1 | Stored IO move bit |
| move_flash | output | 1 | Stored flash/cartridge move bit |
| sprite_sel | output | 1 | Stored sprite bank select |

## Verification
The bench builds the block with its default parameters: four tables of eight slots and 10-bit block numbers. At that size every entry of every table, both high-bit registers and all five device classes can be reached within a few hundred accesses. A behavioural model predicts each output on every cycle. Directed phases exercise inactive-table editing, the closed gate and the IO override. A long random phase then mixes register writes with ordinary accesses, so that table switches land between edits.

// File: rtl/mmu_pkg.sv
package mmu_pkg;
  typedef enum logic [2:0] {
    DEV_SRAM  = 3'd0,
    DEV_FLASH = 3'd1,
    DEV_CART  = 3'd2,
    DEV_RSVD  = 3'd3,
    DEV_IO    = 3'd4
  } dev_e;

  // control register field positions (decoded by software)
  localparam int unsigned MC_EDIT_EN   = 7;
  localparam int unsigned MC_EDIT_LO   = 4;
  localparam int unsigned MC_XSRAM     = 3;
  localparam int unsigned MC_ACT_LO    = 0;
  localparam int unsigned IC_SPRITE    = 6;
  localparam int unsigned IC_MOVE_FL   = 5;
  localparam int unsigned IC_MOVE_IO   = 4;
  localparam int unsigned IC_PAGE_HI   = 3;
  localparam int unsigned IC_IO_OFF    = 2;
  localparam int unsigned IC_PAGE_LO   = 0;
endpackage

// File: rtl/mmu_rst_sync.sv
module mmu_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/mmu_ctrl_regs.sv
module mmu_ctrl_regs
  import mmu_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned TBL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_mem,
  input  logic              wr_io,
  input  logic [DATA_W-1:0] wdata,
  output logic              edit_en,
  output logic [TBL_W-1:0]  edit_tbl,
  output logic [TBL_W-1:0]  act_tbl,
  output logic              xsram_en,
  output logic              io_off,
  output logic [2:0]        io_page,
  output logic              move_io,
  output logic              move_flash,
  output logic              sprite_sel,
  output logic [DATA_W-1:0] mem_rd,
  output logic [DATA_W-1:0] io_rd
);
  logic             edit_en_q, edit_en_d;
  logic [TBL_W-1:0] edit_tbl_q, edit_tbl_d;
  logic [TBL_W-1:0] act_q, act_d;
  logic             xsram_q, xsram_d;
  logic             io_off_q, io_off_d;
  logic             pg_hi_q, pg_hi_d;
  logic [1:0]       pg_lo_q, pg_lo_d;
  logic             mv_io_q, mv_io_d;
  logic             mv_fl_q, mv_fl_d;
  logic             spr_q, spr_d;
  logic             mem_en, io_en;

  assign mem_en = wr_mem;
  assign io_en  = wr_io;

  always_comb begin
    edit_en_d  = edit_en_q;
    edit_tbl_d = edit_tbl_q;
    act_d      = act_q;
    xsram_d    = xsram_q;
    if (wr_mem) begin
      edit_en_d  = wdata[MC_EDIT_EN];
      edit_tbl_d = wdata[MC_EDIT_LO +: TBL_W];
      act_d      = wdata[MC_ACT_LO +: TBL_W];
      xsram_d    = wdata[MC_XSRAM];
    end
  end

  always_comb begin
    io_off_d = io_off_q;
    pg_hi_d  = pg_hi_q;
    pg_lo_d  = pg_lo_q;
    mv_io_d  = mv_io_q;
    mv_fl_d  = mv_fl_q;
    spr_d    = spr_q;
    if (wr_io) begin
      io_off_d = wdata[IC_IO_OFF];
      pg_hi_d  = wdata[IC_PAGE_HI];
      pg_lo_d  = wdata[IC_PAGE_LO +: 2];
      mv_io_d  = wdata[IC_MOVE_IO];
      mv_fl_d  = wdata[IC_MOVE_FL];
      spr_d    = wdata[IC_SPRITE];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edit_en_q  <= 1'b0;
      edit_tbl_q <= '0;
      act_q      <= '0;
      xsram_q    <= 1'b0;
    end else if (mem_en) begin
      edit_en_q  <= edit_en_d;
      edit_tbl_q <= edit_tbl_d;
      act_q      <= act_d;
      xsram_q    <= xsram_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      io_off_q <= 1'b0;
      pg_hi_q  <= 1'b0;
      pg_lo_q  <= 2'b00;
      mv_io_q  <= 1'b0;
      mv_fl_q  <= 1'b0;
      spr_q    <= 1'b0;
    end else if (io_en) begin
      io_off_q <= io_off_d;
      pg_hi_q  <= pg_hi_d;
      pg_lo_q  <= pg_lo_d;
      mv_io_q  <= mv_io_d;
      mv_fl_q  <= mv_fl_d;
      spr_q    <= spr_d;
    end
  end

  assign edit_en    = edit_en_q;
  assign edit_tbl   = edit_tbl_q;
  assign act_tbl    = act_q;
  assign xsram_en   = xsram_q;
  assign io_off     = io_off_q;
  assign io_page    = {pg_hi_q, pg_lo_q};
  assign move_io    = mv_io_q;
  assign move_flash = mv_fl_q;
  assign sprite_sel = spr_q;

  always_comb begin
    mem_rd = '0;
    mem_rd[MC_EDIT_EN]           = edit_en_q;
    mem_rd[MC_EDIT_LO +: TBL_W]  = edit_tbl_q;
    mem_rd[MC_XSRAM]             = xsram_q;
    mem_rd[MC_ACT_LO +: TBL_W]   = act_q;
    io_rd = '0;
    io_rd[IC_SPRITE]             = spr_q;
    io_rd[IC_MOVE_FL]            = mv_fl_q;
    io_rd[IC_MOVE_IO]            = mv_io_q;
    io_rd[IC_PAGE_HI]            = pg_hi_q;
    io_rd[IC_IO_OFF]             = io_off_q;
    io_rd[IC_PAGE_LO +: 2]       = pg_lo_q;
  end

  // R3: a write to the memory control register sets the active table next cycle
  a_r3_act_follows: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mem |=> act_tbl == $past(wdata[MC_ACT_LO +: TBL_W]));

  // R10: IO page follows the IO control register next cycle
  a_r10_page_follows: assert property (@(posedge clk) disable iff (!rst_n)
    wr_io |=> io_page == {$past(wdata[IC_PAGE_HI]), $past(wdata[IC_PAGE_LO +: 2])});

  // R4: register untouched when not written
  a_r4_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mem |=> $stable(mem_rd));
endmodule

// File: rtl/mmu_lut_bank.sv
module mmu_lut_bank #(
  parameter int unsigned TABLES = 4,
  parameter int unsigned SLOTS  = 8,
  parameter int unsigned BLK_W  = 10,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned TBL_W    = $clog2(TABLES),
  localparam int unsigned SLOT_W   = $clog2(SLOTS),
  localparam int unsigned HI_W     = BLK_W - DATA_W,
  localparam int unsigned HI_PER   = DATA_W / HI_W,
  localparam int unsigned PER_W    = $clog2(HI_PER),
  localparam int unsigned HI_IDX_W = (SLOT_W > PER_W) ? SLOT_W - PER_W : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [TBL_W-1:0]    act_tbl,
  input  logic [SLOT_W-1:0]   slot,
  input  logic [TBL_W-1:0]    edit_tbl,
  input  logic                wr_lo,
  input  logic                wr_hi,
  input  logic [SLOT_W-1:0]   lo_idx,
  input  logic [HI_IDX_W-1:0] hi_idx,
  input  logic [DATA_W-1:0]   wdata,
  output logic [BLK_W-1:0]    xlat_block,
  output logic [DATA_W-1:0]   rd_lo,
  output logic [DATA_W-1:0]   rd_hi
);
  logic [BLK_W-1:0]  tbl_q [TABLES][SLOTS];
  logic [BLK_W-1:0]  tbl_d [TABLES][SLOTS];
  logic [SLOT_W-1:0] hi_base;
  logic              lut_en;

  assign hi_base = SLOT_W'({hi_idx, {PER_W{1'b0}}});
  assign lut_en  = wr_lo | wr_hi;

  always_comb begin
    tbl_d = tbl_q;
    if (wr_lo) tbl_d[edit_tbl][lo_idx][DATA_W-1:0] = wdata;
    if (wr_hi) begin
      for (int k = 0; k < HI_PER; k++)
        tbl_d[edit_tbl][hi_base + SLOT_W'(k)][BLK_W-1:DATA_W] = wdata[k*HI_W +: HI_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int t = 0; t < TABLES; t++)
        for (int s = 0; s < SLOTS; s++)
          tbl_q[t][s] <= BLK_W'(s);
    end else if (lut_en) begin
      tbl_q <= tbl_d;
    end
  end

  assign xlat_block = tbl_q[act_tbl][slot];
  assign rd_lo      = tbl_q[edit_tbl][lo_idx][DATA_W-1:0];

  generate
    for (genvar g = 0; g < HI_PER; g++) begin : g_hi_rd
      assign rd_hi[g*HI_W +: HI_W] = tbl_q[edit_tbl][hi_base + SLOT_W'(g)][BLK_W-1:DATA_W];
    end
  endgenerate

  // R6: a low-byte edit lands in the edited table at the addressed slot
  a_r6_lo_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> tbl_q[$past(edit_tbl)][$past(lo_idx)][DATA_W-1:0] == $past(wdata));

  // R8: edits of another table leave the active translation alone
  a_r8_edit_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    (lut_en && edit_tbl != act_tbl) |=> tbl_q[$past(act_tbl)][$past(slot)] == $past(xlat_block));
endmodule

// File: rtl/mmu_xlat.sv
module mmu_xlat
  import mmu_pkg::*;
#(
  parameter int unsigned SLOT_W  = 3,
  parameter int unsigned BLK_W   = 10,
  parameter int unsigned IO_SLOT = 6
) (
  input  logic [SLOT_W-1:0] slot,
  input  logic [BLK_W-1:0]  entry,
  input  logic              io_off,
  output logic [BLK_W-1:0]  phys_block,
  output dev_e              dev
);
  logic [7:0] low;
  dev_e       mem_dev;

  assign low = entry[7:0];

  always_comb begin
    unique case (low[7:6])
      2'b00:   mem_dev = DEV_SRAM;
      2'b01:   mem_dev = DEV_FLASH;
      2'b10:   mem_dev = low[5] ? DEV_RSVD : DEV_CART;
      default: mem_dev = DEV_RSVD;
    endcase
  end

  always_comb begin
    if (!io_off && slot == SLOT_W'(IO_SLOT)) dev = DEV_IO;
    else                                     dev = mem_dev;
  end

  assign phys_block = entry;
endmodule

// File: rtl/mmu_bank_xlat.sv
module mmu_bank_xlat
  import mmu_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned BLK_W   = 10,
  parameter int unsigned TABLES  = 4,
  parameter int unsigned SLOTS   = 8,
  parameter int unsigned IO_SLOT = 6,
  localparam int unsigned TBL_W    = $clog2(TABLES),
  localparam int unsigned SLOT_W   = $clog2(SLOTS),
  localparam int unsigned OFF_W    = ADDR_W - SLOT_W,
  localparam int unsigned HI_W     = BLK_W - DATA_W,
  localparam int unsigned HI_PER   = DATA_W / HI_W,
  localparam int unsigned HI_REGS  = SLOTS / HI_PER,
  localparam int unsigned PER_W    = $clog2(HI_PER),
  localparam int unsigned HI_IDX_W = (SLOT_W > PER_W) ? SLOT_W - PER_W : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic              cpu_we,
  output logic [7:0]        cpu_rdata,
  output logic              reg_hit,
  output logic [9:0]        phys_block,
  output logic [12:0]       phys_offset,
  output logic [2:0]        dev_class,
  output logic [2:0]        io_page,
  output logic              xsram_en,
  output logic              move_io,
  output logic              move_flash,
  output logic              sprite_sel
);
  localparam int unsigned A_MEM_CTRL = 0;
  localparam int unsigned A_IO_CTRL  = 1;
  localparam int unsigned A_HI_BASE  = 2;
  localparam int unsigned A_LO_BASE  = 8;

  logic              rst_i_n;
  logic              edit_en, io_off;
  logic [TBL_W-1:0]  edit_tbl, act_tbl;
  logic [DATA_W-1:0] mem_rd, io_rd, rd_lo, rd_hi;
  logic [BLK_W-1:0]  entry;
  logic [SLOT_W-1:0] slot;
  logic              hit_mem, hit_io, in_hi, in_lo, hit_hi, hit_lo;
  dev_e              dev;

  mmu_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  assign slot    = cpu_addr[ADDR_W-1 -: SLOT_W];
  assign hit_mem = cpu_addr == ADDR_W'(A_MEM_CTRL);
  assign hit_io  = cpu_addr == ADDR_W'(A_IO_CTRL);
  assign in_hi   = cpu_addr >= ADDR_W'(A_HI_BASE) && cpu_addr < ADDR_W'(A_HI_BASE + HI_REGS);
  assign in_lo   = cpu_addr >= ADDR_W'(A_LO_BASE) && cpu_addr < ADDR_W'(A_LO_BASE + SLOTS);
  assign hit_hi  = edit_en && in_hi;
  assign hit_lo  = edit_en && in_lo;
  assign reg_hit = hit_mem | hit_io | hit_hi | hit_lo;

  mmu_ctrl_regs #(.DATA_W(DATA_W), .TBL_W(TBL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_i_n),
    .wr_mem(cpu_we && hit_mem), .wr_io(cpu_we && hit_io), .wdata(cpu_wdata),
    .edit_en(edit_en), .edit_tbl(edit_tbl), .act_tbl(act_tbl), .xsram_en(xsram_en),
    .io_off(io_off), .io_page(io_page), .move_io(move_io), .move_flash(move_flash),
    .sprite_sel(sprite_sel), .mem_rd(mem_rd), .io_rd(io_rd)
  );

  mmu_lut_bank #(.TABLES(TABLES), .SLOTS(SLOTS), .BLK_W(BLK_W), .DATA_W(DATA_W)) u_lut (
    .clk(clk), .rst_n(rst_i_n), .act_tbl(act_tbl), .slot(slot), .edit_tbl(edit_tbl),
    .wr_lo(cpu_we && hit_lo), .wr_hi(cpu_we && hit_hi),
    .lo_idx(cpu_addr[SLOT_W-1:0]), .hi_idx(cpu_addr[HI_IDX_W-1:0]),
    .wdata(cpu_wdata), .xlat_block(entry), .rd_lo(rd_lo), .rd_hi(rd_hi)
  );

  mmu_xlat #(.SLOT_W(SLOT_W), .BLK_W(BLK_W), .IO_SLOT(IO_SLOT)) u_xlat (
    .slot(slot), .entry(entry), .io_off(io_off), .phys_block(phys_block), .dev(dev)
  );

  always_comb begin
    cpu_rdata = '0;
    if (hit_mem)     cpu_rdata = mem_rd;
    else if (hit_io) cpu_rdata = io_rd;
    else if (hit_hi) cpu_rdata = rd_hi;
    else if (hit_lo) cpu_rdata = rd_lo;
  end

  assign phys_offset = cpu_addr[OFF_W-1:0];
  assign dev_class   = dev;

  // R9: closed gate keeps the editing addresses as plain memory
  a_r9_gate_closed: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!edit_en && (in_hi || in_lo)) |-> (!reg_hit && cpu_rdata == '0));

  // R10: IO window overrides slot IO_SLOT while enabled
  a_r10_io_override: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!io_off && slot == SLOT_W'(IO_SLOT)) |-> dev_class == 3'(DEV_IO));

  // R11: cartridge class only for low bytes 0x80..0x9F
  a_r11_cart_range: assert property (@(posedge clk) disable iff (!rst_i_n)
    (dev_class == 3'(DEV_CART)) |-> phys_block[7:5] == 3'b100);

  // R12: the control registers are always claimed
  a_r12_ctrl_hit: assert property (@(posedge clk) disable iff (!rst_i_n)
    (cpu_addr < ADDR_W'(2)) |-> reg_hit);
endmodule

// File: tb/test_mmu_bank_xlat.sv
module test_mmu_bank_xlat;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic [7:0]  cpu_wdata;
  logic        cpu_we;
  logic [7:0]  cpu_rdata;
  logic        reg_hit;
  logic [9:0]  phys_block;
  logic [12:0] phys_offset;
  logic [2:0]  dev_class;
  logic [2:0]  io_page;
  logic        xsram_en, move_io, move_flash, sprite_sel;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  int mtbl [4][8];
  int m0, m1;

  always #(PERIOD/2) clk = ~clk;

  mmu_bank_xlat i_mmu_bank_xlat (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_we(cpu_we),
    .cpu_rdata(cpu_rdata), .reg_hit(reg_hit), .phys_block(phys_block), .phys_offset(phys_offset),
    .dev_class(dev_class), .io_page(io_page), .xsram_en(xsram_en), .move_io(move_io),
    .move_flash(move_flash), .sprite_sel(sprite_sel)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int dev_of(input int blk);
    int lo = blk & 255;
    if (lo < 64)  return 0;
    if (lo < 128) return 1;
    if (lo < 160) return 2;
    return 3;
  endfunction

  function automatic bit m_hit(input int a);
    bit ed = ((m0 >> 7) & 1) != 0;
    return a == 0 || a == 1 || (ed && (a == 2 || a == 3 || (a >= 8 && a <= 15)));
  endfunction

  function automatic int m_rdata(input int a);
    int et = (m0 >> 4) & 3;
    int r = 0;
    if (!m_hit(a)) return 0;
    if (a == 0) return m0;
    if (a == 1) return m1;
    if (a == 2 || a == 3) begin
      for (int k = 0; k < 4; k++) r |= ((mtbl[et][(a-2)*4+k] >> 8) & 3) << (2*k);
      return r;
    end
    return mtbl[et][a-8] & 255;
  endfunction

  function automatic string rd_tag(input int a);
    if (a == 0) return "R4";
    if (a == 1) return "R5";
    if (a == 2 || a == 3) return "R7";
    if (a >= 8 && a <= 15) return "R6";
    return "R9";
  endfunction

  task automatic compare_all(input int a);
    int at   = m0 & 3;
    int sl   = a >> 13;
    int blk  = mtbl[at][sl];
    int ioff = (m1 >> 2) & 1;
    int edev = (sl == 6 && ioff == 0) ? 4 : dev_of(blk);
    chk("R1", "offset", int'(phys_offset), a & 16'h1FFF);
    chk("R3", "block", int'(phys_block), blk);
    chk("R11", "device", int'(dev_class), edev);
    chk("R10", "io_page", int'(io_page), ((m1 >> 3) & 1) * 4 + (m1 & 3));
    chk("R12", "reg_hit", int'(reg_hit), int'(m_hit(a)));
    chk(rd_tag(a), "rdata", int'(cpu_rdata), m_rdata(a));
    chk("R4", "xsram_en", int'(xsram_en), (m0 >> 3) & 1);
    chk("R5", "exports", {sprite_sel, move_flash, move_io}, (m1 >> 4) & 7);
  endtask

  task automatic model_write(input int a, input int d);
    bit ed = ((m0 >> 7) & 1) != 0;
    int et = (m0 >> 4) & 3;
    if (a == 0) m0 = d & 8'hBB;
    else if (a == 1) m1 = d & 8'h7F;
    else if (ed && (a == 2 || a == 3)) begin
      for (int k = 0; k < 4; k++)
        mtbl[et][(a-2)*4+k] = (mtbl[et][(a-2)*4+k] & 255) | (((d >> (2*k)) & 3) << 8);
    end else if (ed && a >= 8 && a <= 15)
      mtbl[et][a-8] = (mtbl[et][a-8] & 10'h300) | (d & 255);
  endtask

  task automatic step(input int a, input int d, input bit we);
    @(negedge clk);
    cpu_addr = 16'(a); cpu_wdata = 8'(d); cpu_we = we;
    #(PERIOD/4);
    compare_all(a);
    @(posedge clk);
    if (we) model_write(a, d);
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    cpu_addr = '0; cpu_wdata = '0; cpu_we = 1'b0; rst_n = 1'b0;
    m0 = 0; m1 = 0;
    for (int t = 0; t < 4; t++) for (int s = 0; s < 8; s++) mtbl[t][s] = s;
    repeat (5) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R2: reset state
    @(negedge clk); cpu_addr = 16'h0000; #1;
    chk("R2", "ctrl0 after reset", int'(cpu_rdata), 0);
    cpu_addr = 16'h0001; #1;
    chk("R2", "ctrl1 after reset", int'(cpu_rdata), 0);
    cpu_addr = 16'hC123; #1;
    chk("R2", "io window on page 0", int'(dev_class), 4);
    chk("R2", "io page 0", int'(io_page), 0);
    for (int s = 0; s < 8; s++) begin
      cpu_addr = 16'((s << 13) | 16'h0155); #1;
      chk("R2", "identity map", int'(phys_block), s);
    end

    // R1: slot sweep
    for (int s = 0; s < 8; s++) step((s << 13) | (s * 517 & 16'h1FFF), 0, 0);

    // R6/R7/R8: edit table 2 while table 0 is active
    step(0, 8'hA0, 1);
    step(8, 8'h05, 1); step(9, 8'h45, 1); step(10, 8'h85, 1); step(11, 8'hA5, 1);
    step(12, 8'h3F, 1); step(13, 8'h7F, 1); step(14, 8'h9F, 1); step(15, 8'hE0, 1);
    step(2, 8'hE4, 1); step(3, 8'h1B, 1);
    for (int a = 8; a < 16; a++) step(a, 0, 0);
    step(2, 0, 0); step(3, 0, 0);
    @(negedge clk); cpu_we = 0; cpu_addr = 16'h2000; #1;
    chk("R8", "active table untouched by edit", int'(phys_block), 1);

    // R3: switch to table 2, IO window off
    step(1, 8'h04, 1);
    step(0, 8'hA2, 1);
    for (int s = 0; s < 8; s++) step((s << 13) | 16'h0ABC, 0, 0);
    @(negedge clk); cpu_addr = 16'h4000; #1;
    chk("R11", "cart block 0x285", int'(dev_class), 2);

    // R10: IO window on page 5
    step(1, 8'h09, 1);
    step(16'hC000, 0, 0); step(16'hDFFF, 0, 0);
    // R5: exported bits
    step(1, 8'hF4, 1);
    step(1, 0, 0); step(16'hC000, 0, 0);

    // R9: gate closed, edits must not land
    step(0, 8'h22, 1);
    step(8, 8'h55, 1); step(2, 8'hFF, 1); step(15, 8'h11, 1); step(3, 8'hAA, 1);
    step(8, 0, 0);
    step(0, 8'hA2, 1);
    step(8, 0, 0); step(2, 0, 0); step(15, 0, 0); step(3, 0, 0);
    @(negedge clk); cpu_addr = 16'h0008; #1;
    chk("R9", "slot0 low byte kept", int'(cpu_rdata), 8'h05);

    // random mix
    for (int i = 0; i < 600; i++) begin
      int sel = $urandom % 4;
      int a;
      if (sel == 0)      a = $urandom % 16;
      else if (sel == 1) a = $urandom % 65536;
      else if (sel == 2) a = $urandom % 2;
      else               a = 8 + ($urandom % 8);
      step(a, $urandom % 256, ($urandom % 2) == 1);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule